// File: doc/BRIEF.md
# BCD Clock-Calendar with Snapshot Register Bank

This block keeps time of day and calendar date in packed BCD, from hundredths of a second up to a two-digit year. A set of running counters advances on a 100 Hz tick enable that comes from an external prescaler. Software never reads those counters directly. It sees a separate bank of snapshot registers, and all of them are reloaded from the counters in one clock cycle whenever the seconds value advances.

The snapshot bank sits in the highest sixteen byte addresses of a byte-wide synchronous memory bus. Every lower address is ordinary read/write storage. Two freeze bits in the control byte stop the reloads:
- The read freeze lets software read a time that cannot change under it.
- The write freeze lets software compose a new time and date. Clearing the write freeze copies that time into the running counters in one cycle.

Neither freeze stops the counters. An oscillator-stop bit halts all counting. It is set at reset, so the clock is stopped until software clears it.

Top module: `rtc_shadow_clock`

## Requirements
- R1: Addresses below the top sixteen are byte storage. A bus read (chip-select high, write-enable low) returns the addressed byte on `bus_rdata` in the cycle after the request, and `bus_rdata` holds its value in cycles with no read request.
- R2: The register offsets within the top sixteen addresses are:
  - 0: hundredths
  - 1: seconds, with bit 7 as oscillator stop
  - 2: minutes
  - 3: hours
  - 4: day of month
  - 5: month
  - 6: year
  - 7: control

  After reset the time reads 00:00:00.00 on day 01, month 01, year 00. The seconds byte reads 0x80 because oscillator stop is 1, and the control byte reads 0x00.
- R3: While oscillator stop is 1, ticks are ignored and no reload happens. Bit 7 of the seconds byte can be written at any time. Once it is cleared, counting resumes from the halted value.
- R4: On the tick that takes hundredths from 99 to 00, all seven snapshot fields are reloaded together in the following cycle, unless a freeze bit is set.
- R5: Seconds and minutes roll over 59 to 00, hours roll over 23 to 00, and hundredths roll over 99 to 00, each carrying into the next field.
- R6: The day of month wraps to 01 after 28, 29, 30 or 31, depending on the month. February has 29 days when the binary value of the two-digit year is a multiple of 4. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R7: While control bit 6 (read freeze) is 1, no reloads happen, but the counters keep counting.
- R8: After read freeze returns to 0, the next reload shows the time counted across the whole frozen interval.
- R9: While control bit 7 (write freeze) is 1, reloads are blocked and writes to the time fields take effect. A control write that changes bit 7 from 1 to 0 copies the snapshot into the counters at that edge.
- R10: When both freeze bits are 0, bus writes to offsets 0 to 6 are ignored. The one exception is bit 7 of the seconds byte.
- R11: A control write that sets a freeze bit on the same edge as a pending reload does not block that reload.
- R12: Offsets 8 to 15 read 0x00 and ignore writes. Control bits 5 to 0 are plain storage that reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_100hz | input | 1 | One-cycle enable, one per hundredth of a second |
| bus_cs | input | 1 | Chip select for a single-cycle access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |

## Verification
The assertions assume that only the block itself writes its counters, so every counter value is legal BCD inside its field's range. The bench therefore writes only valid BCD dates and times through the write freeze. The assertions also assume that a time-field write reaches the snapshot only under a freeze. The bench keeps its read freeze free of any time-field writes. The bench drives ticks only when no bus access is in flight, so the expected second count is a simple tick total divided by 100.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
    logic [7:0] hund;
  } rtc_time_t;

  localparam int NUM_FIELDS = 7;
  localparam int OFF_HUND   = 0;
  localparam int OFF_SEC    = 1;
  localparam int OFF_DAY    = 4;
  localparam int OFF_MON    = 5;
  localparam int OFF_CTRL   = 7;
  localparam int RD_FRZ_BIT = 6;
  localparam int WR_FRZ_BIT = 7;

  localparam rtc_time_t RESET_TIME = '{year: 8'h00, mon: 8'h01, day: 8'h01,
                                       hour: 8'h00, min: 8'h00, sec: 8'h00,
                                       hund: 8'h00};

  // Advance a BCD value by one, wrapping from last to first.
  function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] last,
                                          input logic [7:0] first);
    if (v == last) return first;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Last day of a BCD month; a year whose binary value is a multiple of 4 is leap.
  function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                input logic [7:0] year);
    logic leap;
    leap = year[4] ? (year[3:0] == 4'd2 || year[3:0] == 4'd6)
                   : (year[3:0] == 4'd0 || year[3:0] == 4'd4 || year[3:0] == 4'd8);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_bcd_counters.sv
module rtc_bcd_counters
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      run,
  input  logic      set_en,
  input  rtc_time_t set_val,
  output rtc_time_t cur,
  output logic      sec_stb
);

  rtc_time_t nxt;
  logic adv, c_hund, c_sec, c_min, c_hour, c_day, c_mon;

  always_comb begin
    adv    = tick && run;
    c_hund = (cur.hund == 8'h99);
    c_sec  = c_hund && (cur.sec  == 8'h59);
    c_min  = c_sec  && (cur.min  == 8'h59);
    c_hour = c_min  && (cur.hour == 8'h23);
    c_day  = c_hour && (cur.day  == month_last_day(cur.mon, cur.year));
    c_mon  = c_day  && (cur.mon  == 8'h12);
    nxt = cur;
    if (adv) begin
      nxt.hund = bcd_step(cur.hund, 8'h99, 8'h00);
      if (c_hund) nxt.sec  = bcd_step(cur.sec,  8'h59, 8'h00);
      if (c_sec)  nxt.min  = bcd_step(cur.min,  8'h59, 8'h00);
      if (c_min)  nxt.hour = bcd_step(cur.hour, 8'h23, 8'h00);
      if (c_hour) nxt.day  = bcd_step(cur.day, month_last_day(cur.mon, cur.year), 8'h01);
      if (c_day)  nxt.mon  = bcd_step(cur.mon,  8'h12, 8'h01);
      if (c_mon)  nxt.year = bcd_step(cur.year, 8'h99, 8'h00);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= RESET_TIME;
      sec_stb <= 1'b0;
    end else begin
      sec_stb <= adv && c_hund;
      if (set_en) cur <= set_val;
      else        cur <= nxt;
    end
  end

endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic [3:0] reg_off,
  input  logic [7:0] wdata,
  input  logic       sec_stb,
  input  rtc_time_t  cur,
  output rtc_time_t  shadow,
  output logic       osc_stop,
  output logic [7:0] ctrl,
  output logic       set_en,
  output logic [7:0] rd_val
);

  logic [7:0] bank     [NUM_FIELDS];
  logic [7:0] cur_byte [NUM_FIELDS];
  logic       frozen;

  assign frozen = ctrl[RD_FRZ_BIT] || ctrl[WR_FRZ_BIT];
  assign set_en = reg_wr && (reg_off == 4'(OFF_CTRL)) && ctrl[WR_FRZ_BIT] && !wdata[WR_FRZ_BIT];

  always_comb begin
    for (int k = 0; k < NUM_FIELDS; k++) begin
      cur_byte[k]        = cur[k*8 +: 8];
      shadow[k*8 +: 8]   = bank[k];
    end
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [7:0] RST_BYTE = (i == OFF_DAY || i == OFF_MON) ? 8'h01 : 8'h00;
    localparam logic [7:0] WR_MASK  = (i == OFF_SEC) ? 8'h7F : 8'hFF;
    always_ff @(posedge clk) begin
      if (rst)
        bank[i] <= RST_BYTE;
      else if (reg_wr && reg_off == 4'(i) && frozen)
        bank[i] <= wdata & WR_MASK;
      else if (sec_stb && !frozen)
        bank[i] <= cur_byte[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_stop <= 1'b1;
      ctrl     <= 8'h00;
    end else if (reg_wr) begin
      if (reg_off == 4'(OFF_SEC))  osc_stop <= wdata[7];
      if (reg_off == 4'(OFF_CTRL)) ctrl     <= wdata;
    end
  end

  always_comb begin
    rd_val = 8'h00;
    for (int k = 0; k < NUM_FIELDS; k++)
      if (reg_off == 4'(k)) rd_val = bank[k];
    if (reg_off == 4'(OFF_SEC))  rd_val[7] = osc_stop;
    if (reg_off == 4'(OFF_CTRL)) rd_val = ctrl;
  end

endmodule

// File: rtl/rtc_storage_ram.sv
module rtc_storage_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (re) rdata_q <= mem[addr];
  end

endmodule

// File: rtl/rtc_shadow_clock.sv
module rtc_shadow_clock
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_100hz,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);

  localparam int REG_AW = 4;

  rtc_time_t  cur_time, shadow_time;
  logic       sec_stb, set_en, osc_stop;
  logic [7:0] ctrl, rd_val, ram_q, reg_q;
  logic       is_reg, reg_wr, ram_wr, rd_req, sel_q;

  assign is_reg = &bus_addr[ADDR_W-1:REG_AW];
  assign reg_wr = bus_cs && bus_we && is_reg;
  assign ram_wr = bus_cs && bus_we && !is_reg;
  assign rd_req = bus_cs && !bus_we;

  rtc_bcd_counters u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_100hz),
    .run     (!osc_stop),
    .set_en  (set_en),
    .set_val (shadow_time),
    .cur     (cur_time),
    .sec_stb (sec_stb)
  );

  rtc_shadow_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_off  (bus_addr[REG_AW-1:0]),
    .wdata    (bus_wdata),
    .sec_stb  (sec_stb),
    .cur      (cur_time),
    .shadow   (shadow_time),
    .osc_stop (osc_stop),
    .ctrl     (ctrl),
    .set_en   (set_en),
    .rd_val   (rd_val)
  );

  rtc_storage_ram #(.ADDR_W(ADDR_W), .DATA_W(8)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .we      (ram_wr),
    .re      (rd_req),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata_q (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      reg_q <= 8'h00;
    end else if (rd_req) begin
      sel_q <= is_reg;
      reg_q <= rd_val;
    end
  end

  assign bus_rdata = sel_q ? reg_q : ram_q;

endmodule

// File: rtl/rtc_shadow_clock_chk.sv
module rtc_shadow_clock_chk
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       sec_stb,
  input logic [7:0] ctrl,
  input logic       osc_stop,
  input logic       set_en,
  input rtc_time_t  cur,
  input rtc_time_t  shadow,
  input logic       reg_wr,
  input logic       rd_req,
  input logic [7:0] bus_rdata
);

  // R1
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(bus_rdata));

  // R3
  osc_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (osc_stop && !set_en) |=> $stable(cur));

  // R4 and R11: a pending reload lands even if a freeze is written on that edge
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_stb && ctrl[7:6] == 2'b00) |=> (shadow == $past(cur)));

  // R5
  time_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cur.hund[3:0] <= 4'd9) && (cur.sec <= 8'h59) && (cur.sec[3:0] <= 4'd9) &&
    (cur.min <= 8'h59) && (cur.min[3:0] <= 4'd9) && (cur.hour <= 8'h23));

  // R6
  date_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cur.day != 8'h00) && (cur.day <= 8'h31) && (cur.mon != 8'h00) && (cur.mon <= 8'h12));

  // R7
  read_freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl[6] && !reg_wr) |=> $stable(shadow));

endmodule

bind rtc_shadow_clock rtc_shadow_clock_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sec_stb   (sec_stb),
  .ctrl      (ctrl),
  .osc_stop  (osc_stop),
  .set_en    (set_en),
  .cur       (cur_time),
  .shadow    (shadow_time),
  .reg_wr    (reg_wr),
  .rd_req    (rd_req),
  .bus_rdata (bus_rdata)
);

// File: tb/rtc_shadow_clock_bench.sv
module rtc_shadow_clock_bench;

  localparam int AW = 8;
  localparam logic [7:0] A_HUND = 8'hF0, A_SEC = 8'hF1, A_MIN = 8'hF2, A_HOUR = 8'hF3,
                         A_DAY = 8'hF4, A_MON = 8'hF5, A_YEAR = 8'hF6, A_CTRL = 8'hF7;

  logic          clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic          bus_cs = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = 8'h00, bus_rdata;
  int            n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  rtc_shadow_clock #(.ADDR_W(AW)) u_rtc_shadow_clock (
    .clk(clk), .rst(rst), .tick_100hz(tick), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_cs = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic ticks_raw(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    ticks_raw(n);
    @(negedge clk);
  endtask

  task automatic set_time(input int y, input int mo, input int d, input int h,
                          input int mi, input int s);
    wr(A_CTRL, 8'h80);
    wr(A_HUND, 8'h00);
    wr(A_SEC,  to_bcd(s));
    wr(A_MIN,  to_bcd(mi));
    wr(A_HOUR, to_bcd(h));
    wr(A_DAY,  to_bcd(d));
    wr(A_MON,  to_bcd(mo));
    wr(A_YEAR, to_bcd(y));
    wr(A_CTRL, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset state
    rd_chk(A_HUND, 8'h00, "R2 hund");
    rd_chk(A_SEC,  8'h80, "R2 sec/osc");
    rd_chk(A_MIN,  8'h00, "R2 min");
    rd_chk(A_HOUR, 8'h00, "R2 hour");
    rd_chk(A_DAY,  8'h01, "R2 day");
    rd_chk(A_MON,  8'h01, "R2 mon");
    rd_chk(A_YEAR, 8'h00, "R2 year");
    rd_chk(A_CTRL, 8'h00, "R2 ctrl");

    // R12 reserved offsets and control storage bits
    for (int a = 8'hF8; a <= 8'hFF; a++) wr(8'(a), 8'h77);
    for (int a = 8'hF8; a <= 8'hFF; a++) rd_chk(8'(a), 8'h00, "R12 reserved");
    wr(A_CTRL, 8'h15);
    rd_chk(A_CTRL, 8'h15, "R12 ctrl storage");
    wr(A_CTRL, 8'h00);

    // R1 storage sweep
    for (int a = 0; a < 240; a++) wr(8'(a), 8'((a * 7 + 3) ^ 8'h5A));
    for (int a = 0; a < 240; a++) rd_chk(8'(a), 8'((a * 7 + 3) ^ 8'h5A), "R1 ram");

    // R10 writes ignored without freeze
    wr(A_MIN, 8'h33);
    wr(A_HOUR, 8'h12);
    wr(A_DAY, 8'h09);
    rd_chk(A_MIN,  8'h00, "R10 min");
    rd_chk(A_HOUR, 8'h00, "R10 hour");
    rd_chk(A_DAY,  8'h01, "R10 day");

    // R3 oscillator stop
    ticks(150);
    rd_chk(A_SEC, 8'h80, "R3 stopped");
    wr(A_SEC, 8'h00);
    rd_chk(A_SEC, 8'h00, "R3 osc cleared");
    ticks(99);
    rd_chk(A_SEC, 8'h00, "R3 no early load");
    ticks(1);
    rd_chk(A_SEC, 8'h01, "R3 resumed from halt");
    rd_chk(A_HUND, 8'h00, "R4 hund at load");
    rd_chk(A_DAY, 8'h01, "R4 day at load");

    // R9 write freeze: written values held, then copied
    wr(A_CTRL, 8'h80);
    wr(A_HOUR, 8'h09);
    wr(A_MIN, 8'h59);
    wr(A_SEC, 8'h58);
    ticks(100);
    rd_chk(A_SEC, 8'h58, "R9 held under freeze");
    rd_chk(A_MIN, 8'h59, "R9 written min");
    wr(A_CTRL, 8'h00);
    ticks(100);
    rd_chk(A_SEC, 8'h59, "R9 copied");
    ticks(100);
    // R5 rollover of seconds and minutes into hours
    rd_chk(A_SEC,  8'h00, "R5 sec wrap");
    rd_chk(A_MIN,  8'h00, "R5 min wrap");
    rd_chk(A_HOUR, 8'h10, "R5 hour carry");

    // R5 hour wrap into the day
    set_time(23, 6, 10, 23, 59, 59);
    ticks(100);
    rd_chk(A_HOUR, 8'h00, "R5 hour wrap");
    rd_chk(A_DAY,  8'h11, "R5 day carry");

    // R6 month ends, two years, all months
    for (int yi = 0; yi < 2; yi++) begin
      for (int m = 1; m <= 12; m++) begin
        int y = (yi == 0) ? 23 : 24;
        set_time(y, m, days_in(m, y), 23, 59, 59);
        ticks(100);
        rd_chk(A_DAY,  8'h01, "R6 day wrap");
        rd_chk(A_MON,  to_bcd(m == 12 ? 1 : m + 1), "R6 month");
        rd_chk(A_YEAR, to_bcd(m == 12 ? (y + 1) % 100 : y), "R6 year");
      end
    end
    set_time(24, 2, 28, 23, 59, 59);
    ticks(100);
    rd_chk(A_DAY, 8'h29, "R6 leap day");
    rd_chk(A_MON, 8'h02, "R6 leap month");
    set_time(99, 12, 31, 23, 59, 59);
    ticks(100);
    rd_chk(A_YEAR, 8'h00, "R6 year wrap");
    rd_chk(A_MON,  8'h01, "R6 year wrap month");

    // R7 and R8 read freeze
    set_time(23, 6, 15, 10, 20, 30);
    ticks(100);
    rd_chk(A_SEC, 8'h31, "R7 before freeze");
    wr(A_CTRL, 8'h40);
    ticks(300);
    rd_chk(A_SEC, 8'h31, "R7 frozen sec");
    rd_chk(A_MIN, 8'h20, "R7 frozen min");
    rd_chk(A_CTRL, 8'h40, "R7 ctrl");
    wr(A_CTRL, 8'h00);
    rd_chk(A_SEC, 8'h31, "R8 no load yet");
    ticks(100);
    rd_chk(A_SEC, 8'h35, "R8 caught up");

    // R11 freeze written on the reload edge
    ticks_raw(100);
    wr(A_CTRL, 8'h40);
    rd_chk(A_SEC, 8'h36, "R11 load completed");
    ticks(100);
    rd_chk(A_SEC, 8'h36, "R11 frozen after");
    wr(A_CTRL, 8'h00);
    ticks(100);
    rd_chk(A_SEC, 8'h38, "R8 resumed");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule